// File: doc/BRIEF.md
# Dual-Clock Flagged FIFO with Depth-Cascade Pulses

This block is an 18-bit first-in first-out buffer whose write port and read port each run on their own clock. Words enter on the write clock and leave in the same order on the read clock. The status outputs are all active low: an empty flag, a half-full flag, a programmable almost-empty flag, and a copy of the empty flag delayed by one read clock. The pointers cross between the two clock domains as Gray codes through two-flop synchronizers. Each flag is computed in its own domain, from the local pointer and the synchronized copy of the other pointer.

Two pins have two functions, and a mode input chooses between them. A small state machine in each clock domain loads that mode, together with one configuration bit, while reset is held. From then on it stays in its state until the next reset. The states are COMPAT and ENH. The only transition that changes the state is reset entry, which loads COMPAT when `mode_sel` is 0 and ENH when it is 1. Outside reset, each state returns to itself.

In COMPAT the two pins carry one-cycle expansion pulses for chaining devices in depth. The almost-empty threshold is then the built-in default. In ENH the same pins carry the half-full flag and the delayed empty copy. The almost-empty threshold then comes from `ae_offset`, and the captured configuration bits choose which clock domain registers the half-full flag and whether the almost-empty flag is registered.

Top module: `flagged_fifo_cascade`

## Requirements
- R1: While `rst_n` is low and the clocks run, `empty_n` and `pae_n` read 0 and `hf_wxo_n` reads 1. `ef2_rxo_n` reads 0 when `mode_sel` is 1 and reads 1 when `mode_sel` is 0.
- R2: Accepted words leave in the order they were written. A read is accepted at a rising `rclk` edge where `rd_en` is 1 and `empty_n` is 1, and `rdata` shows the word after that same edge.
- R3: `empty_n` is registered on `rclk` and is 0 exactly when the read domain sees no stored word. While it is 0, `rd_en` is ignored, the read pointer holds and `rdata` keeps its value.
- R4: Once DEPTH words are stored, further writes are dropped and the stored words are unchanged.
- R5: In ENH, `hf_wxo_n` is 0 when more than DEPTH/2 words are stored. The flag is registered on `rclk` when the captured `cfg_hf_on_rclk` is 1 and on `wclk` when it is 0.
- R6: `pae_n` is 0 when the stored count is at or below the threshold. The threshold is DEPTH/8-1 (63 for 512 words) in COMPAT and `ae_offset` in ENH. In ENH the flag is registered on `rclk` when the captured `cfg_ae_registered` is 1 and combinational otherwise. In COMPAT it is combinational.
- R7: In ENH, `ef2_rxo_n` equals the value `empty_n` had one `rclk` cycle earlier.
- R8: In COMPAT, `hf_wxo_n` idles at 1. It goes to 0 for exactly one `wclk` cycle, after the edge that writes memory address DEPTH-1. Addresses are taken in order from 0 after reset and wrap.
- R9: In COMPAT, `ef2_rxo_n` idles at 1. It goes to 0 for exactly one `rclk` cycle, after the edge that reads address DEPTH-1.
- R10: The mode and the configuration bits are sampled only while `rst_n` is low. Changing `mode_sel` or the configuration inputs afterwards has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Active-low reset, synchronous in both domains; both clocks must run while it is low |
| mode_sel | input | 1 | Sampled during reset: 0 selects COMPAT, 1 selects ENH |
| cfg_hf_on_rclk | input | 1 | Sampled during reset: half-full flag registered on rclk (1) or wclk (0) |
| cfg_ae_registered | input | 1 | Sampled during reset: almost-empty flag registered on rclk (1) or combinational (0) |
| ae_offset | input | log2(DEPTH) | Almost-empty threshold used in ENH |
| wr_en | input | 1 | Write request |
| wdata | input | DATA_W | Write data |
| rd_en | input | 1 | Read request |
| rdata | output | DATA_W | Read data, registered on rclk |
| empty_n | output | 1 | Empty flag, active low |
| pae_n | output | 1 | Almost-empty flag, active low |
| hf_wxo_n | output | 1 | ENH: half-full flag; COMPAT: write-expansion pulse (active low) |
| ef2_rxo_n | output | 1 | ENH: delayed empty copy; COMPAT: read-expansion pulse (active low) |

## Verification
On every clock edge, the checker confirms four things: `rdata` holds while `empty_n` is low, the delayed empty copy tracks `empty_n` one read clock behind, each expansion pulse lasts a single cycle, and neither mode state changes outside reset. The bench's scenarios cover the rest. They show data order through a pointer wrap, dropped writes at full, the half-full and almost-empty thresholds in both registration choices, a live change of the offset, and the placement of each pulse on the last address. They also show that a change of `mode_sel` after reset leaves the pins in their enhanced role.

// File: rtl/ffx_pkg.sv
`timescale 1ns/1ps
package ffx_pkg;
    typedef enum logic {
        ST_COMPAT = 1'b0,
        ST_ENH    = 1'b1
    } port_state_e;
endpackage

// File: rtl/ffx_mode_fsm.sv
`timescale 1ns/1ps
// Per-domain mode state machine: loaded during reset, frozen afterwards.
module ffx_mode_fsm
    import ffx_pkg::*;
#(
    parameter int NCFG = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_sel,
    input  logic [NCFG-1:0] cfg_in,
    output port_state_e     state,
    output logic [NCFG-1:0] cfg
);
    port_state_e     st_q, st_d;
    logic [NCFG-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= mode_sel ? ST_ENH : ST_COMPAT;
            cap_q <= cfg_in;
        end else begin
            st_q  <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_COMPAT: st_d = ST_COMPAT;
            ST_ENH:    st_d = ST_ENH;
        endcase
    end

    assign state = st_q;
    assign cfg   = cap_q;
endmodule

// File: rtl/ffx_mem.sv
`timescale 1ns/1ps
module ffx_mem #(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 512,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (!rst_n)  rdata_q <= '0;
        else if (re) rdata_q <= store[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/ffx_wr_ctrl.sv
`timescale 1ns/1ps
module ffx_wr_ctrl
    import ffx_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  port_state_e   state,
    input  logic          hf_on_rclk,
    input  logic          wr_en,
    input  logic [PW-1:0] rgray_async,
    input  logic          hf_rd_n,
    output logic [PW-1:0] wgray,
    output logic [AW-1:0] waddr,
    output logic          wr_fire,
    output logic          hf_wxo_n
);
    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);
    localparam logic [AW-1:0] LAST_AD  = AW'(DEPTH - 1);

    logic [PW-1:0] wbin_q, wgray_q, rg_s1, rg_s2;
    logic [PW-1:0] rbin_s, wbin_nx, fill_nx;
    logic          full, hf_w_q, wxo_q;

    always_comb begin
        rbin_s[PW-1] = rg_s2[PW-1];
        for (int i = PW - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rg_s2[i];
    end

    assign full    = (wbin_q - rbin_s) == FULL_CNT;
    assign wr_fire = wr_en && !full;
    assign wbin_nx = wbin_q + {{(PW-1){1'b0}}, wr_fire};
    assign fill_nx = wbin_nx - rbin_s;
    assign waddr   = wbin_q[AW-1:0];
    assign wgray   = wgray_q;

    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin_q  <= '0;
            wgray_q <= '0;
            rg_s1   <= '0;
            rg_s2   <= '0;
            hf_w_q  <= 1'b1;
            wxo_q   <= 1'b1;
        end else begin
            rg_s1   <= rgray_async;
            rg_s2   <= rg_s1;
            wbin_q  <= wbin_nx;
            wgray_q <= wbin_nx ^ (wbin_nx >> 1);
            hf_w_q  <= !(fill_nx > HALF_CNT);
            wxo_q   <= !(wr_fire && (waddr == LAST_AD));
        end
    end

    always_comb begin
        hf_wxo_n = 1'b1;
        unique case (state)
            ST_ENH:    hf_wxo_n = hf_on_rclk ? hf_rd_n : hf_w_q;
            ST_COMPAT: hf_wxo_n = wxo_q;
        endcase
    end
endmodule

// File: rtl/ffx_rd_ctrl.sv
`timescale 1ns/1ps
module ffx_rd_ctrl
    import ffx_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  port_state_e   state,
    input  logic          ae_registered,
    input  logic          rd_en,
    input  logic [AW-1:0] ae_offset,
    input  logic [PW-1:0] wgray_async,
    output logic [PW-1:0] rgray,
    output logic [AW-1:0] raddr,
    output logic          rd_fire,
    output logic          empty_n,
    output logic          hf_rd_n,
    output logic          pae_n,
    output logic          ef2_rxo_n
);
    localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);
    localparam logic [PW-1:0] DEF_OFS  = PW'(DEPTH / 8 - 1);
    localparam logic [AW-1:0] LAST_AD  = AW'(DEPTH - 1);

    logic [PW-1:0] rbin_q, rgray_q, wg_s1, wg_s2;
    logic [PW-1:0] wbin_s, rbin_nx, fill_nx, fill_now, ofs_sel;
    logic          empty_n_q, hf_q, pae_q, ef2_q, rxo_q, pae_live;

    always_comb begin
        wbin_s[PW-1] = wg_s2[PW-1];
        for (int i = PW - 2; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wg_s2[i];
    end

    assign rd_fire  = rd_en && empty_n_q;
    assign rbin_nx  = rbin_q + {{(PW-1){1'b0}}, rd_fire};
    assign fill_nx  = wbin_s - rbin_nx;
    assign fill_now = wbin_s - rbin_q;
    assign ofs_sel  = (state == ST_ENH) ? {1'b0, ae_offset} : DEF_OFS;
    assign pae_live = !(fill_now <= ofs_sel);
    assign raddr    = rbin_q[AW-1:0];
    assign rgray    = rgray_q;
    assign empty_n  = empty_n_q;
    assign hf_rd_n  = hf_q;

    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rbin_q    <= '0;
            rgray_q   <= '0;
            wg_s1     <= '0;
            wg_s2     <= '0;
            empty_n_q <= 1'b0;
            hf_q      <= 1'b1;
            pae_q     <= 1'b0;
            ef2_q     <= 1'b0;
            rxo_q     <= 1'b1;
        end else begin
            wg_s1     <= wgray_async;
            wg_s2     <= wg_s1;
            rbin_q    <= rbin_nx;
            rgray_q   <= rbin_nx ^ (rbin_nx >> 1);
            empty_n_q <= (fill_nx != '0);
            hf_q      <= !(fill_nx > HALF_CNT);
            pae_q     <= !(fill_nx <= ofs_sel);
            ef2_q     <= empty_n_q;
            rxo_q     <= !(rd_fire && (raddr == LAST_AD));
        end
    end

    always_comb begin
        pae_n     = 1'b0;
        ef2_rxo_n = 1'b1;
        unique case (state)
            ST_ENH: begin
                pae_n     = ae_registered ? pae_q : pae_live;
                ef2_rxo_n = ef2_q;
            end
            ST_COMPAT: begin
                pae_n     = pae_live;
                ef2_rxo_n = rxo_q;
            end
        endcase
    end
endmodule

// File: rtl/flagged_fifo_cascade.sv
`timescale 1ns/1ps
module flagged_fifo_cascade
    import ffx_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 512,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              cfg_hf_on_rclk,
    input  logic              cfg_ae_registered,
    input  logic [AW-1:0]     ae_offset,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              empty_n,
    output logic              pae_n,
    output logic              hf_wxo_n,
    output logic              ef2_rxo_n
);
    localparam int PW = AW + 1;

    port_state_e   wr_state, rd_state;
    logic [0:0]    w_cfg, r_cfg;
    logic [PW-1:0] wgray, rgray;
    logic [AW-1:0] waddr, raddr;
    logic          wr_fire, rd_fire, hf_rd_n;

    ffx_mode_fsm #(.NCFG(1)) u_wfsm (
        .clk(wclk), .rst_n(rst_n), .mode_sel(mode_sel),
        .cfg_in(cfg_hf_on_rclk), .state(wr_state), .cfg(w_cfg)
    );

    ffx_mode_fsm #(.NCFG(1)) u_rfsm (
        .clk(rclk), .rst_n(rst_n), .mode_sel(mode_sel),
        .cfg_in(cfg_ae_registered), .state(rd_state), .cfg(r_cfg)
    );

    ffx_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(wdata),
        .rclk(rclk), .rst_n(rst_n), .re(rd_fire), .raddr(raddr), .rdata(rdata)
    );

    ffx_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .state(wr_state), .hf_on_rclk(w_cfg[0]),
        .wr_en(wr_en), .rgray_async(rgray), .hf_rd_n(hf_rd_n),
        .wgray(wgray), .waddr(waddr), .wr_fire(wr_fire), .hf_wxo_n(hf_wxo_n)
    );

    ffx_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .state(rd_state), .ae_registered(r_cfg[0]),
        .rd_en(rd_en), .ae_offset(ae_offset), .wgray_async(wgray),
        .rgray(rgray), .raddr(raddr), .rd_fire(rd_fire), .empty_n(empty_n),
        .hf_rd_n(hf_rd_n), .pae_n(pae_n), .ef2_rxo_n(ef2_rxo_n)
    );
endmodule

// File: rtl/ffx_checker.sv
`timescale 1ns/1ps
module ffx_checker
    import ffx_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input logic              wclk,
    input logic              rclk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              empty_n,
    input logic [DATA_W-1:0] rdata,
    input logic              hf_wxo_n,
    input logic              ef2_rxo_n,
    input port_state_e       wr_state,
    input port_state_e       rd_state
);
    assert_read_hold_R3: assert property (@(posedge rclk) disable iff (!rst_n)
        (!empty_n && rd_en) |=> $stable(rdata));

    assert_ef2_lag_R7: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_state == ST_ENH) |-> (ef2_rxo_n == $past(empty_n)));

    assert_wxo_single_R8: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_state == ST_COMPAT && !hf_wxo_n) |=> hf_wxo_n);

    assert_rxo_single_R9: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_state == ST_COMPAT && !ef2_rxo_n) |=> ef2_rxo_n);

    assert_wmode_fixed_R10: assert property (@(posedge wclk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(wr_state));

    assert_rmode_fixed_R10: assert property (@(posedge rclk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(rd_state));
endmodule

bind flagged_fifo_cascade ffx_checker #(.DATA_W(DATA_W)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .rd_en(rd_en),
    .empty_n(empty_n), .rdata(rdata), .hf_wxo_n(hf_wxo_n),
    .ef2_rxo_n(ef2_rxo_n), .wr_state(wr_state), .rd_state(rd_state)
);

// File: tb/flagged_fifo_cascade_bench.sv
`timescale 1ns/1ps
module flagged_fifo_cascade_bench;
    localparam int DW    = 18;
    localparam int DEPTH = 512;
    localparam int AW    = 9;

    logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
    logic          mode_sel = 1'b0, cfg_hf = 1'b0, cfg_ae = 1'b0;
    logic [AW-1:0] ae_offset = '0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          empty_n, pae_n, hf_wxo_n, ef2_rxo_n;

    flagged_fifo_cascade #(.DATA_W(DW), .DEPTH(DEPTH)) u_flagged_fifo_cascade (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .mode_sel(mode_sel),
        .cfg_hf_on_rclk(cfg_hf), .cfg_ae_registered(cfg_ae), .ae_offset(ae_offset),
        .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en), .rdata(rdata),
        .empty_n(empty_n), .pae_n(pae_n), .hf_wxo_n(hf_wxo_n), .ef2_rxo_n(ef2_rxo_n)
    );

    always #2 wclk = ~wclk;
    always #3 rclk = ~rclk;

    int total = 0, bad = 0;
    int model[$];
    int wp = 0, rp = 0, ofs_model = 63;
    bit enh = 1'b0;
    logic [DW-1:0] last_rd = '0;

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(bit m, bit h, bit a);
        rst_n = 1'b0; mode_sel = m; cfg_hf = h; cfg_ae = a;
        wr_en = 1'b0; rd_en = 1'b0;
        repeat (4) @(negedge rclk);
        chk(empty_n == 1'b0, "R1 empty_n", empty_n, 0);
        chk(pae_n == 1'b0, "R1 pae_n", pae_n, 0);
        chk(hf_wxo_n == 1'b1, "R1 hf_wxo_n", hf_wxo_n, 1);
        chk(ef2_rxo_n == !m, "R1 ef2_rxo_n", ef2_rxo_n, !m);
        @(negedge wclk);
        rst_n = 1'b1;
        // R10: flip the reset-sampled inputs once reset is released
        mode_sel = !m; cfg_hf = !h; cfg_ae = !a;
        model.delete(); wp = 0; rp = 0; enh = m; last_rd = '0;
        repeat (4) @(negedge rclk);
    endtask

    task automatic write_n(int n);
        for (int i = 0; i < n; i++) begin
            bit fire, pulse;
            int v;
            v = (wp * 37 + i * 5 + 3) & 'h3FFFF;
            fire = (model.size() < DEPTH);
            wr_en = 1'b1; wdata = DW'(v);
            @(negedge wclk);
            pulse = 1'b0;
            if (fire) begin
                model.push_back(v);
                pulse = ((wp % DEPTH) == DEPTH - 1);
                wp++;
            end
            if (!enh) chk(hf_wxo_n == !pulse, "R8 write pulse", hf_wxo_n, !pulse);
        end
        wr_en = 1'b0;
    endtask

    task automatic read_n(int n);
        int done = 0;
        while (done < n) begin
            bit fire, pulse, prev_e;
            fire = empty_n; prev_e = empty_n;
            rd_en = 1'b1;
            @(negedge rclk);
            pulse = 1'b0;
            if (fire) begin
                int e;
                e = model.pop_front();
                chk(rdata == DW'(e), "R2 data", rdata, e);
                last_rd = rdata;
                pulse = ((rp % DEPTH) == DEPTH - 1);
                rp++; done++;
            end else begin
                chk(rdata == last_rd, "R3 hold", rdata, last_rd);
            end
            if (!enh) chk(ef2_rxo_n == !pulse, "R9 read pulse", ef2_rxo_n, !pulse);
            else      chk(ef2_rxo_n == prev_e, "R7 lag", ef2_rxo_n, prev_e);
        end
        rd_en = 1'b0;
    endtask

    task automatic settle_flags();
        repeat (8) @(negedge wclk);
        repeat (8) @(negedge rclk);
        chk(empty_n == (model.size() != 0), "R3 empty", empty_n, model.size() != 0);
        chk(pae_n == !(model.size() <= ofs_model), "R6 pae", pae_n, !(model.size() <= ofs_model));
        if (enh) begin
            chk(hf_wxo_n == !(model.size() > DEPTH / 2), "R5 hf", hf_wxo_n, !(model.size() > DEPTH / 2));
            chk(ef2_rxo_n == empty_n, "R7 settled", ef2_rxo_n, empty_n);
        end else begin
            chk(hf_wxo_n == 1'b1, "R8 idle", hf_wxo_n, 1);
            chk(ef2_rxo_n == 1'b1, "R9 idle", ef2_rxo_n, 1);
        end
    endtask

    initial begin
        #(200000 * 4);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // Compatibility mode, default threshold 63
        do_reset(1'b0, 1'b0, 1'b0);
        ofs_model = 63;
        rd_en = 1'b1;
        repeat (3) begin
            @(negedge rclk);
            chk(empty_n == 1'b0 && rdata == '0, "R3 read while empty", rdata, 0);
        end
        rd_en = 1'b0;
        write_n(100); settle_flags();
        read_n(40);   settle_flags();
        read_n(60);   settle_flags();
        write_n(500); settle_flags();
        read_n(500);  settle_flags();
        write_n(520); settle_flags();
        chk(model.size() == DEPTH, "R4 full drop", model.size(), DEPTH);
        read_n(DEPTH); settle_flags();

        // Enhanced mode, half-full on wclk, registered almost-empty
        ae_offset = 9'd20;
        do_reset(1'b1, 1'b0, 1'b1);
        ofs_model = 20;
        chk(ef2_rxo_n == 1'b0, "R10 mode held", ef2_rxo_n, 0);
        write_n(300); settle_flags();
        read_n(285);  settle_flags();
        ae_offset = 9'd10; ofs_model = 10;
        settle_flags();
        read_n(15);   settle_flags();

        // Enhanced mode, half-full on rclk, combinational almost-empty
        ae_offset = 9'd30;
        do_reset(1'b1, 1'b1, 1'b0);
        ofs_model = 30;
        write_n(257); settle_flags();
        read_n(1);    settle_flags();
        read_n(256);  settle_flags();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule